// File: doc/BRIEF.md
# Deadline-Ordered Task List with Schedulability Check

This block keeps the ready tasks of a real-time scheduler in ascending order of absolute deadline and checks at the same time whether every task can finish on time. It is a chain of identical cells. Each cell holds one list entry: a task identifier, an absolute deadline, and the absolute time at which that task would finish if every entry ahead of it ran first. A small sequencer walks a task table from index 0 upwards. The table sits outside the block and is read through the `task_idx` output. Each task is inserted with four fixed steps: compare, shift, fill and check. After the last task the head cell names the task to run next, and each cell reports whether its deadline would be missed.

A pass starts with a one-cycle `start` pulse while the block is idle. The pass first empties the whole list and then inserts `task_cnt` tasks. Tasks are read at the current system time `now_time`, which must stay constant during the pass. Cell 0 takes `now_time` as the base of the cumulative sum, so all finish times are absolute. Each step takes two clock cycles, so a pass of k tasks takes 1 + 8k cycles. An empty cell acts as if its deadline were the largest possible value. Among equal deadlines, the task presented earlier stays ahead.

Top module: `edf_task_list`

## Requirements
- R1: After reset `busy`, `done`, `head_valid`, `sched_error` and every bit of `viol_mark` are 0.
- R2: A `start` pulse is accepted only while `busy` is 0. A `start` that arrives during a pass changes neither the timing nor the result of that pass.
- R3: After a pass the valid entries are in non-decreasing deadline order. `head_valid` is 1 and `head_id` is the identifier of a task with the smallest deadline.
- R4: When deadlines are equal, the task presented earlier (lower table index) is ahead in the list. An entry moves back only for a strictly smaller incoming deadline.
- R5: Bit p of `viol_mark` (p = 0 is the head) is 1 exactly when position p holds a task and `now_time` plus the sum of execution times of positions 0..p is strictly greater than that task's deadline. Empty positions are never marked.
- R6: `sched_error` is the OR of all bits of `viol_mark`.
- R7: When `start` is accepted on clock edge E, `done` is 1 for exactly one cycle, after edge E+1+8k, where k is the effective task count and k ≥ 1. `busy` stays 1 from edge E+1 up to and including the `done` cycle.
- R8: Each pass first empties every cell, so positions at or beyond the new task count are empty afterwards, whatever the previous pass left there.
- R9: A `task_cnt` larger than NUM_CELLS is treated as NUM_CELLS.
- R10: While idle, `head_id`, `head_valid`, `viol_mark` and `sched_error` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scheduling pass (one-cycle pulse, idle only) |
| task_cnt | input | $clog2(NUM_CELLS+1) | Number of table entries to insert |
| now_time | input | TIME_W | Absolute current time, constant during a pass |
| task_idx | output | $clog2(NUM_CELLS) | Table index of the task currently on the bus |
| bus_id | input | ID_W | Identifier of table entry `task_idx` |
| bus_deadline | input | TIME_W | Absolute deadline of table entry `task_idx` |
| bus_exec | input | TIME_W | Remaining execution time of table entry `task_idx` |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| head_id | output | ID_W | Identifier in list position 0 |
| head_valid | output | 1 | List position 0 holds a task |
| viol_mark | output | NUM_CELLS | Per-position deadline violation, bit 0 = head |
| sched_error | output | 1 | Any position violates its deadline |

## Verification
The checker tests structural invariants of the chain on every cycle, including during each insertion. Valid entries form a prefix and are ordered by deadline. Shift marks form a suffix. Empty cells hold zeros. A violation mark appears only on a valid cell. The checker also covers the `start`/`busy`/`done` handshake and the idle hold of the head. Other properties need whole passes compared against an arithmetic model: the exact head identifier, tie placement, the cumulative-sum violation pattern, the 1 + 8k latency, clamping of oversized counts, and immunity to a second `start`. The bench covers these with directed corner cases and a sweep over many random task sets on a four-cell list.

// File: rtl/edf_pkg.sv
package edf_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_CLEAR = 2'd1,
      SEQ_STEP  = 2'd2,
      SEQ_FIN   = 2'd3
   } seq_state_e;

   // Order of the four insertion steps; the sequencer advances through them in this order.
   typedef enum logic [1:0] {
      STP_COMPARE = 2'd0,
      STP_SHIFT   = 2'd1,
      STP_FILL    = 2'd2,
      STP_CHECK   = 2'd3
   } step_e;

   typedef struct packed {
      logic clear;
      logic compare;
      logic shift;
      logic fill;
      logic check;
   } cell_ctl_t;

endpackage

// File: rtl/edf_seq.sv
module edf_seq
   import edf_pkg::*;
#(
   parameter  int NUM_CELLS = 16,
   localparam int CNT_W     = $clog2(NUM_CELLS + 1),
   localparam int IDX_W     = $clog2(NUM_CELLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] task_cnt,
   output logic [IDX_W-1:0] task_idx,
   output logic             busy,
   output logic             done,
   output cell_ctl_t        ctl
);

   seq_state_e       state_q;
   step_e            step_q;
   logic             phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             act;
   logic             last_task;

   assign last_task = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         step_q  <= STP_COMPARE;
         phase_q <= 1'b0;
         idx_q   <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  cnt_q   <= (task_cnt > CNT_W'(NUM_CELLS)) ? CNT_W'(NUM_CELLS) : task_cnt;
                  state_q <= SEQ_CLEAR;
               end
            end
            SEQ_CLEAR: begin
               idx_q   <= '0;
               step_q  <= STP_COMPARE;
               phase_q <= 1'b0;
               state_q <= (cnt_q == '0) ? SEQ_FIN : SEQ_STEP;
            end
            SEQ_STEP: begin
               if (!phase_q) begin
                  phase_q <= 1'b1;
               end else begin
                  phase_q <= 1'b0;
                  step_q  <= step_e'(step_q + 2'd1);
                  if (step_q == STP_CHECK) begin
                     if (last_task) state_q <= SEQ_FIN;
                     else           idx_q   <= idx_q + IDX_W'(1);
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign act         = (state_q == SEQ_STEP) && phase_q;
   assign ctl.clear   = (state_q == SEQ_CLEAR);
   assign ctl.compare = act && (step_q == STP_COMPARE);
   assign ctl.shift   = act && (step_q == STP_SHIFT);
   assign ctl.fill    = act && (step_q == STP_FILL);
   assign ctl.check   = act && (step_q == STP_CHECK);
   assign busy        = (state_q != SEQ_IDLE);
   assign done        = (state_q == SEQ_FIN);
   assign task_idx    = idx_q;

endmodule

// File: rtl/edf_cell.sv
module edf_cell
   import edf_pkg::*;
#(
   parameter int ID_W   = 5,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cell_ctl_t         ctl,
   input  logic [ID_W-1:0]   bus_id,
   input  logic [TIME_W-1:0] bus_deadline,
   input  logic [TIME_W-1:0] bus_exec,
   input  logic              prv_valid,
   input  logic              prv_mark,
   input  logic [ID_W-1:0]   prv_id,
   input  logic [TIME_W-1:0] prv_deadline,
   input  logic [TIME_W-1:0] prv_cum,
   output logic              valid,
   output logic              mark,
   output logic              viol,
   output logic [ID_W-1:0]   id,
   output logic [TIME_W-1:0] deadline,
   output logic [TIME_W-1:0] cum
);

   logic is_gap;
   logic is_moved;

   // First marked cell receives the new task; marked cells behind it got shifted entries.
   assign is_gap   = mark && !prv_mark;
   assign is_moved = mark && prv_mark;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         mark     <= 1'b0;
         viol     <= 1'b0;
         id       <= '0;
         deadline <= '0;
         cum      <= '0;
      end else if (ctl.clear) begin
         valid    <= 1'b0;
         mark     <= 1'b0;
         viol     <= 1'b0;
         id       <= '0;
         deadline <= '0;
         cum      <= '0;
      end else if (ctl.compare) begin
         mark <= !valid || (deadline > bus_deadline);
      end else if (ctl.shift) begin
         if (mark) begin
            valid    <= prv_valid;
            id       <= prv_id;
            deadline <= prv_deadline;
            cum      <= prv_cum;
         end
      end else if (ctl.fill) begin
         if (is_gap) begin
            valid    <= 1'b1;
            id       <= bus_id;
            deadline <= bus_deadline;
            cum      <= prv_cum + bus_exec;
         end else if (is_moved && valid) begin
            cum <= cum + bus_exec;
         end
      end else if (ctl.check) begin
         viol <= valid && (cum > deadline);
      end
   end

endmodule

// File: rtl/edf_task_list.sv
module edf_task_list
   import edf_pkg::*;
#(
   parameter  int NUM_CELLS = 16,
   parameter  int ID_W      = 5,
   parameter  int TIME_W    = 16,
   localparam int CNT_W     = $clog2(NUM_CELLS + 1),
   localparam int IDX_W     = $clog2(NUM_CELLS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CNT_W-1:0]     task_cnt,
   input  logic [TIME_W-1:0]    now_time,
   output logic [IDX_W-1:0]     task_idx,
   input  logic [ID_W-1:0]      bus_id,
   input  logic [TIME_W-1:0]    bus_deadline,
   input  logic [TIME_W-1:0]    bus_exec,
   output logic                 busy,
   output logic                 done,
   output logic [ID_W-1:0]      head_id,
   output logic                 head_valid,
   output logic [NUM_CELLS-1:0] viol_mark,
   output logic                 sched_error
);

   if (NUM_CELLS < 2) begin : g_bad_cells
      $error("edf_task_list: NUM_CELLS must be at least 2");
   end
   if (ID_W < 1 || TIME_W < 2) begin : g_bad_widths
      $error("edf_task_list: ID_W and TIME_W too small");
   end

   cell_ctl_t                   ctl;
   logic [NUM_CELLS-1:0]        cell_valid;
   logic [NUM_CELLS-1:0]        cell_mark;
   logic [NUM_CELLS-1:0]        cell_viol;
   logic [NUM_CELLS*ID_W-1:0]   id_flat;
   logic [NUM_CELLS*TIME_W-1:0] dl_flat;
   logic [NUM_CELLS*TIME_W-1:0] cum_flat;

   edf_seq #(.NUM_CELLS(NUM_CELLS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .task_cnt (task_cnt),
      .task_idx (task_idx),
      .busy     (busy),
      .done     (done),
      .ctl      (ctl)
   );

   for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
      logic              p_valid;
      logic              p_mark;
      logic [ID_W-1:0]   p_id;
      logic [TIME_W-1:0] p_dl;
      logic [TIME_W-1:0] p_cum;

      if (g == 0) begin : g_head
         // Constant predecessor: always valid, never marked, sum base is the current time.
         assign p_valid = 1'b1;
         assign p_mark  = 1'b0;
         assign p_id    = '0;
         assign p_dl    = '0;
         assign p_cum   = now_time;
      end else begin : g_link
         assign p_valid = cell_valid[g-1];
         assign p_mark  = cell_mark[g-1];
         assign p_id    = id_flat[(g-1)*ID_W +: ID_W];
         assign p_dl    = dl_flat[(g-1)*TIME_W +: TIME_W];
         assign p_cum   = cum_flat[(g-1)*TIME_W +: TIME_W];
      end

      edf_cell #(.ID_W(ID_W), .TIME_W(TIME_W)) u_cell (
         .clk          (clk),
         .rst_n        (rst_n),
         .ctl          (ctl),
         .bus_id       (bus_id),
         .bus_deadline (bus_deadline),
         .bus_exec     (bus_exec),
         .prv_valid    (p_valid),
         .prv_mark     (p_mark),
         .prv_id       (p_id),
         .prv_deadline (p_dl),
         .prv_cum      (p_cum),
         .valid        (cell_valid[g]),
         .mark         (cell_mark[g]),
         .viol         (cell_viol[g]),
         .id           (id_flat[g*ID_W +: ID_W]),
         .deadline     (dl_flat[g*TIME_W +: TIME_W]),
         .cum          (cum_flat[g*TIME_W +: TIME_W])
      );
   end

   assign head_id     = id_flat[ID_W-1:0];
   assign head_valid  = cell_valid[0];
   assign viol_mark   = cell_viol;
   assign sched_error = |(cell_viol & cell_valid);

endmodule

// File: rtl/edf_task_list_chk.sv
module edf_task_list_chk #(
   parameter int NUM_CELLS = 16,
   parameter int ID_W      = 5,
   parameter int TIME_W    = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        start,
   input logic                        busy,
   input logic                        done,
   input logic [ID_W-1:0]             head_id,
   input logic [NUM_CELLS-1:0]        valid_vec,
   input logic [NUM_CELLS-1:0]        mark_vec,
   input logic [NUM_CELLS-1:0]        viol_vec,
   input logic [NUM_CELLS*ID_W-1:0]   id_flat,
   input logic [NUM_CELLS*TIME_W-1:0] dl_flat,
   input logic [NUM_CELLS*TIME_W-1:0] cum_flat
);

   for (genvar g = 0; g < NUM_CELLS; g++) begin : g_each
      assert_viol_on_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
         viol_vec[g] |-> valid_vec[g]);

      assert_empty_cell_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_vec[g] |-> (id_flat[g*ID_W +: ID_W] == '0 && cum_flat[g*TIME_W +: TIME_W] == '0));
   end

   for (genvar g = 0; g < NUM_CELLS - 1; g++) begin : g_pair
      assert_sorted_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
         valid_vec[g+1] |-> (valid_vec[g] &&
            dl_flat[g*TIME_W +: TIME_W] <= dl_flat[(g+1)*TIME_W +: TIME_W]));

      assert_mark_suffix_R4: assert property (@(posedge clk) disable iff (!rst_n)
         mark_vec[g] |-> mark_vec[g+1]);
   end

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(head_id));

endmodule

bind edf_task_list edf_task_list_chk #(
   .NUM_CELLS (NUM_CELLS),
   .ID_W      (ID_W),
   .TIME_W    (TIME_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .head_id   (head_id),
   .valid_vec (cell_valid),
   .mark_vec  (cell_mark),
   .viol_vec  (cell_viol),
   .id_flat   (id_flat),
   .dl_flat   (dl_flat),
   .cum_flat  (cum_flat)
);

// File: tb/tb_edf_task_list.sv
module tb_edf_task_list;

   localparam int N  = 4;
   localparam int IW = 4;
   localparam int TW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    task_cnt = '0;
   logic [TW-1:0] now_time = '0;
   logic [1:0]    task_idx;
   logic [IW-1:0] bus_id;
   logic [TW-1:0] bus_deadline;
   logic [TW-1:0] bus_exec;
   logic          busy, done, head_valid, sched_error;
   logic [IW-1:0] head_id;
   logic [N-1:0]  viol_mark;

   logic [IW-1:0] t_id [N];
   logic [TW-1:0] t_dl [N];
   logic [TW-1:0] t_ex [N];

   int checks = 0;
   int errors = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;

   assign bus_id       = t_id[task_idx];
   assign bus_deadline = t_dl[task_idx];
   assign bus_exec     = t_ex[task_idx];

   edf_task_list #(.NUM_CELLS(N), .ID_W(IW), .TIME_W(TW)) dut (
      .clk, .rst_n, .start, .task_cnt, .now_time, .task_idx,
      .bus_id, .bus_deadline, .bus_exec, .busy, .done,
      .head_id, .head_valid, .viol_mark, .sched_error
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int rnd(input int m);
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'(seed[30:16]) % m;
   endfunction

   task automatic run_pass(input int cnt_in, input int now, input bit poke, input bit hold);
      int k;
      int ord[N];
      int exp_head;
      int cyc;
      logic [N-1:0] ev;
      int cum;
      k = (cnt_in > N) ? N : cnt_in;
      for (int i = 0; i < k; i++) begin
         int pos;
         pos = i;
         for (int j = 0; j < i; j++) begin
            if (t_dl[ord[j]] > t_dl[i]) begin pos = j; break; end
         end
         for (int j = i; j > pos; j--) ord[j] = ord[j-1];
         ord[pos] = i;
      end
      ev = '0;
      cum = now;
      for (int p = 0; p < k; p++) begin
         cum += int'(t_ex[ord[p]]);
         ev[p] = cum > int'(t_dl[ord[p]]);
      end
      exp_head = int'(t_id[ord[0]]);

      now_time = TW'(now);
      task_cnt = 3'(cnt_in);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      cyc = 0;
      while (!done && cyc < 300) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 5) begin start = 1'b1; task_cnt = 3'd1; end
         if (poke && cyc == 6) start = 1'b0;
         if (!done && cyc > 1) chk(busy, "R7 busy during pass", busy, 1);
      end
      chk(cyc == 1 + 8 * k, poke ? "R2 latency with ignored start" :
          (cnt_in > N ? "R9 latency clamped count" : "R7 done latency"), cyc, 1 + 8 * k);
      chk(head_id == IW'(exp_head), "R3 R4 head id", int'(head_id), exp_head);
      chk(head_valid == 1'b1, "R3 head valid", int'(head_valid), 1);
      chk(viol_mark == ev, "R5 R8 violation marks", int'(viol_mark), int'(ev));
      chk(sched_error == (|ev), "R6 error flag", int'(sched_error), int'(|ev));
      @(negedge clk);
      chk(!done && !busy, "R7 done single cycle", int'(done), 0);
      if (hold) begin
         repeat (4) @(negedge clk);
         chk(head_id == IW'(exp_head) && viol_mark == ev, "R10 idle hold",
             int'(viol_mark), int'(ev));
      end
   endtask

   task automatic set_task(input int i, input int id, input int dl, input int ex);
      t_id[i] = IW'(id);
      t_dl[i] = TW'(dl);
      t_ex[i] = TW'(ex);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) set_task(i, 0, 0, 0);
      repeat (3) @(negedge clk);
      chk(!busy && !done && !head_valid && !sched_error && viol_mark == '0,
          "R1 reset state", int'({busy, done, head_valid, sched_error}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Descending deadlines: full reversal, no violation.
      set_task(0, 1, 140, 5); set_task(1, 2, 130, 5);
      set_task(2, 3, 120, 5); set_task(3, 4, 110, 5);
      run_pass(4, 100, 1'b0, 1'b1);
      // Equal deadlines: order of presentation is kept (R4).
      set_task(0, 5, 150, 3); set_task(1, 6, 150, 3);
      set_task(2, 7, 150, 3); set_task(3, 8, 150, 3);
      run_pass(4, 100, 1'b0, 1'b0);
      // Exact fit vs one over (R5 strictness).
      set_task(0, 9, 110, 10); set_task(1, 10, 115, 6);
      set_task(2, 11, 200, 1); set_task(3, 12, 90, 0);
      run_pass(4, 100, 1'b0, 1'b0);
      // Overload from the head.
      set_task(0, 13, 103, 7); set_task(1, 14, 104, 7);
      run_pass(2, 100, 1'b0, 1'b1);
      // Single task after a full list: tail must be empty (R8).
      set_task(0, 15, 400, 2);
      run_pass(1, 50, 1'b0, 1'b0);
      // Oversized count is clamped (R9) and a stray start is ignored (R2).
      set_task(0, 3, 300, 4); set_task(1, 1, 260, 4);
      set_task(2, 2, 260, 4); set_task(3, 0, 280, 4);
      run_pass(7, 250, 1'b0, 1'b0);
      run_pass(4, 250, 1'b1, 1'b0);

      for (int n = 0; n < 200; n++) begin
         int k;
         int now;
         k = 1 + rnd(N);
         now = rnd(500);
         for (int i = 0; i < N; i++) set_task(i, rnd(16), now + rnd(24), rnd(8));
         run_pass(k, now, n % 17 == 3, n % 11 == 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule